// File: doc/BRIEF.md
# Shared-Pin GPIO Port Controller

This block manages an eight-pin parallel port whose pins are normally owned by on-chip serial peripherals. Each pin that can serve the SPI peripheral can instead be used as general-purpose I/O, one pin at a time. Three registers control the port: an output data latch, a direction register and a routing register. The routing register hands selected pins over to the SPI peripheral. Pins that the routing register cannot reach, including those used by the asynchronous serial peripheral, always stay under control of the latch and the direction register.

Software reaches the registers through a simple 16-bit register port with byte enables. Word 0 holds the data latch in its low byte. A read of word 0 returns the levels seen at the pads, not the latch contents. Word 1 holds two registers: routing in the upper byte and direction in the lower byte. Either byte of word 1 can be written on its own. All registers clear on reset, so every pin starts as a GPIO input with its driver off. The intended bring-up order is to write the latch first and then set the direction, so that a pin drives a known value from the first cycle it is enabled.

Top module: `shared_pin_port`

## Requirements
- R1: After reset the data latch, routing and direction registers are zero: `pad_oe` is 8'h00, `pad_out` is 8'h00, and a read of word 1 returns 16'h0000.
- R2: A write to word 0 with `reg_be[0]` set loads `reg_wdata[7:0]` into the data latch. A read of word 0 (`reg_addr`=0) returns `{8'h00, pad_in}`, the live pad levels, regardless of the latch contents.
- R3: A pin with routing bit 0 and direction bit 1 drives `pad_out` equal to its latch bit and `pad_oe`=1. The new value appears in the cycle after the write edge.
- R4: A pin with routing bit 0 and direction bit 0 has `pad_oe`=0. Its `pad_out` still follows the latch bit.
- R5: A pin whose effective routing bit is 1 takes `pad_out` from `per_out` and `pad_oe` from `per_oe` for that pin.
- R6: Only pins in the parameter `SPI_MASK` (default 8'h7B, meaning bits 2 and 7 are not routable) can be routed. The unimplemented routing bits ignore writes and read as 0. Those pins behave as GPIO whatever value is written.
- R7: A write to word 1 updates routing (bits 15:8) only when `reg_be[1]` is set, and updates direction (bits 7:0) only when `reg_be[0]` is set.
- R8: Writing the latch while the direction bits are 0 drives nothing. When a direction bit is later set, the pin's first driven value is the latch bit that was written earlier.
- R9: With `reg_wr`=0, values on `reg_addr`, `reg_be` and `reg_wdata` change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Word select: 0 = data latch / pad levels, 1 = routing and direction |
| reg_be | input | 2 | Byte enables, bit 1 = upper byte |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| per_out | input | 8 | SPI peripheral output value per pin |
| per_oe | input | 8 | SPI peripheral output enable per pin |
| pad_in | input | 8 | Levels observed at the pads |
| pad_out | output | 8 | Value driven to each pad |
| pad_oe | output | 8 | Output enable to each pad |

## Verification
A wrong routing, direction or latch bit shows up directly on `pad_out`/`pad_oe` for the affected pin. It is visible one cycle after the write that set it, because the pin selection is purely combinational after the registers. A corrupted routing or direction register is also visible on the next read of word 1. The bench sweeps every routing byte, every latch byte and every pad byte against an arithmetic model, so a single wrong bit or a mask slip is exposed on the first pattern that exercises that bit.

// File: rtl/spp_pkg.sv
package spp_pkg;

    localparam int PINS   = 8;
    localparam int WORD_W = 2 * PINS;
    localparam int BE_W   = WORD_W / PINS;

    typedef enum logic {
        WORD_DATA = 1'b0,
        WORD_CTRL = 1'b1
    } word_sel_e;

    typedef struct packed {
        logic [PINS-1:0] latch;
        logic [PINS-1:0] route;
        logic [PINS-1:0] dir;
    } port_cfg_t;

    typedef struct packed {
        logic [PINS-1:0] value;
        logic [PINS-1:0] enable;
    } pad_drive_t;

    function automatic logic [PINS-1:0] merge_byte(
        input logic [PINS-1:0] old_v,
        input logic [PINS-1:0] new_v,
        input logic            en,
        input logic [PINS-1:0] keep_mask
    );
        return en ? (new_v & keep_mask) : old_v;
    endfunction

endpackage

// File: rtl/spp_regs.sv
module spp_regs
    import spp_pkg::*;
#(
    parameter logic [PINS-1:0] SPI_MASK = 8'h7B
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  word_sel_e         sel,
    input  logic [BE_W-1:0]   be,
    input  logic [WORD_W-1:0] wdata,
    output port_cfg_t         cfg
);

    localparam logic [PINS-1:0] ALL_ONES = {PINS{1'b1}};

    port_cfg_t cfg_q;
    port_cfg_t cfg_d;

    always_comb begin
        cfg_d = cfg_q;
        if (wr) begin
            unique case (sel)
                WORD_DATA: begin
                    cfg_d.latch = merge_byte(cfg_q.latch, wdata[PINS-1:0], be[0], ALL_ONES);
                end
                WORD_CTRL: begin
                    cfg_d.route = merge_byte(cfg_q.route, wdata[WORD_W-1:PINS], be[1], SPI_MASK);
                    cfg_d.dir   = merge_byte(cfg_q.dir,   wdata[PINS-1:0],      be[0], ALL_ONES);
                end
                default: cfg_d = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg = cfg_q;

    // R6
    route_unimpl_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.route & ~SPI_MASK) == '0);

    // R7
    dir_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && sel == WORD_CTRL && !be[0]) |=> $stable(cfg_q.dir));

    // R7
    route_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && sel == WORD_CTRL && !be[1]) |=> $stable(cfg_q.route));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(cfg_q));

endmodule

// File: rtl/spp_pin_mux.sv
module spp_pin_mux
    import spp_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  port_cfg_t       cfg,
    input  logic [PINS-1:0] per_out,
    input  logic [PINS-1:0] per_oe,
    output pad_drive_t      drive
);

    for (genvar i = 0; i < PINS; i++) begin : g_pin
        always_comb begin
            if (cfg.route[i]) begin
                drive.value[i]  = per_out[i];
                drive.enable[i] = per_oe[i];
            end else begin
                drive.value[i]  = cfg.latch[i];
                drive.enable[i] = cfg.dir[i];
            end
        end

        // R4
        gpio_input_quiet_chk: assert property (@(posedge clk) disable iff (rst)
            (!cfg.route[i] && !cfg.dir[i]) |-> !drive.enable[i]);

        // R5
        periph_follow_chk: assert property (@(posedge clk) disable iff (rst)
            cfg.route[i] |-> (drive.value[i] == per_out[i] && drive.enable[i] == per_oe[i]));

        // R8
        first_drive_chk: assert property (@(posedge clk) disable iff (rst)
            ($rose(drive.enable[i]) && !cfg.route[i]) |-> drive.value[i] == cfg.latch[i]);
    end

endmodule

// File: rtl/spp_read_mux.sv
module spp_read_mux
    import spp_pkg::*;
(
    input  word_sel_e         sel,
    input  port_cfg_t         cfg,
    input  logic [PINS-1:0]   pad_in,
    output logic [WORD_W-1:0] rdata
);

    always_comb begin
        unique case (sel)
            WORD_DATA: rdata = {{PINS{1'b0}}, pad_in};
            WORD_CTRL: rdata = {cfg.route, cfg.dir};
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/shared_pin_port.sv
module shared_pin_port
    import spp_pkg::*;
#(
    parameter logic [7:0] SPI_MASK = 8'h7B
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic        reg_addr,
    input  logic [1:0]  reg_be,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    input  logic [7:0]  per_out,
    input  logic [7:0]  per_oe,
    input  logic [7:0]  pad_in,
    output logic [7:0]  pad_out,
    output logic [7:0]  pad_oe
);

    word_sel_e  sel;
    port_cfg_t  cfg;
    pad_drive_t drive;

    assign sel = word_sel_e'(reg_addr);

    spp_regs #(.SPI_MASK(SPI_MASK)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr    (reg_wr),
        .sel   (sel),
        .be    (reg_be),
        .wdata (reg_wdata),
        .cfg   (cfg)
    );

    spp_pin_mux u_mux (
        .clk     (clk),
        .rst     (rst),
        .cfg     (cfg),
        .per_out (per_out),
        .per_oe  (per_oe),
        .drive   (drive)
    );

    spp_read_mux u_rd (
        .sel    (sel),
        .cfg    (cfg),
        .pad_in (pad_in),
        .rdata  (reg_rdata)
    );

    assign pad_out = drive.value;
    assign pad_oe  = drive.enable;

    // R3
    gpio_out_drive_chk: assert property (@(posedge clk) disable iff (rst)
        ((pad_oe & ~cfg.route) == (cfg.dir & ~cfg.route)));

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> (pad_oe == 8'h00 && cfg == '0));

endmodule

// File: tb/shared_pin_port_test.sv
module shared_pin_port_test;

    localparam logic [7:0] MASK = 8'h7B;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic        reg_addr = 1'b0;
    logic [1:0]  reg_be = 2'b00;
    logic [15:0] reg_wdata = 16'h0000;
    logic [15:0] reg_rdata;
    logic [7:0]  per_out = 8'h00;
    logic [7:0]  per_oe = 8'h00;
    logic [7:0]  pad_in = 8'h00;
    logic [7:0]  pad_out;
    logic [7:0]  pad_oe;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [7:0] m_latch = 8'h00;
    logic [7:0] m_route = 8'h00;
    logic [7:0] m_dir   = 8'h00;

    always #10 clk = ~clk;

    shared_pin_port #(.SPI_MASK(MASK)) uut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .per_out(per_out), .per_oe(per_oe), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic check16(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic addr, input logic [1:0] be, input logic [15:0] data,
                             input logic strobe);
        @(negedge clk);
        reg_wr    = strobe;
        reg_addr  = addr;
        reg_be    = be;
        reg_wdata = data;
        if (strobe) begin
            if (!addr && be[0]) m_latch = data[7:0];
            if (addr && be[1])  m_route = data[15:8] & MASK;
            if (addr && be[0])  m_dir   = data[7:0];
        end
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic check_pads(input string req);
        logic [7:0] eo;
        logic [7:0] ee;
        eo = (m_route & per_out) | (~m_route & m_latch);
        ee = (m_route & per_oe)  | (~m_route & m_dir);
        check16(req, {8'h00, pad_out}, {8'h00, eo});
        check16(req, {8'h00, pad_oe},  {8'h00, ee});
    endtask

    task automatic check_ctrl_read(input string req);
        reg_addr = 1'b1;
        #1;
        check16(req, reg_rdata, {m_route, m_dir});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        check16("R1 pad_oe", {8'h00, pad_oe}, 16'h0000);
        check16("R1 pad_out", {8'h00, pad_out}, 16'h0000);
        check_ctrl_read("R1 ctrl read");

        // R2: read of word 0 is the pad levels, not the latch
        write_reg(1'b0, 2'b11, 16'hFFA5, 1'b1);
        for (int v = 0; v < 256; v++) begin
            pad_in   = 8'(v);
            reg_addr = 1'b0;
            #1;
            check16("R2 pad read", reg_rdata, {8'h00, 8'(v)});
        end

        // R9: inputs without strobe change nothing
        write_reg(1'b1, 2'b11, 16'hFFFF, 1'b0);
        write_reg(1'b0, 2'b11, 16'h0000, 1'b0);
        check_ctrl_read("R9 ctrl unchanged");
        check_pads("R9 pads unchanged");

        // R8/R3/R4: latch first, then direction
        for (int v = 0; v < 256; v++) begin
            write_reg(1'b0, 2'b01, {8'h00, 8'(v)}, 1'b1);
            check16("R8 no drive before dir", {8'h00, pad_oe}, 16'h0000);
            check_pads("R4 input pins follow latch");
            write_reg(1'b1, 2'b01, 16'h00FF, 1'b1);
            check16("R3 drive value", {8'h00, pad_out}, {8'h00, 8'(v)});
            check16("R3 drive enable", {8'h00, pad_oe}, 16'h00FF);
            write_reg(1'b1, 2'b01, 16'h0000, 1'b1);
        end

        // R5/R6: every routing byte, mixed direction and peripheral patterns
        write_reg(1'b0, 2'b01, 16'h00C3, 1'b1);
        for (int a = 0; a < 256; a++) begin
            per_out = ~8'(a);
            per_oe  = 8'(a) ^ 8'h0F;
            write_reg(1'b1, 2'b11, {8'(a), 8'(a) ^ 8'h5A}, 1'b1);
            check_pads("R5 routed pin mux");
            check_ctrl_read("R6 unimplemented routing bits read 0");
        end

        // R6: bits 2 and 7 cannot be routed
        per_out = 8'hFF;
        per_oe  = 8'hFF;
        write_reg(1'b0, 2'b01, 16'h0000, 1'b1);
        write_reg(1'b1, 2'b11, 16'hFF00, 1'b1);
        check16("R6 unrouted pins stay GPIO", {8'h00, pad_oe & 8'h84}, 16'h0000);

        // R7: byte lanes of word 1
        write_reg(1'b1, 2'b11, 16'hFFAA, 1'b1);
        write_reg(1'b1, 2'b10, 16'h0055, 1'b1);
        check_ctrl_read("R7 upper lane only");
        check16("R7 dir kept", {8'h00, reg_rdata[7:0]}, 16'h00AA);
        write_reg(1'b1, 2'b01, 16'hFF33, 1'b1);
        check_ctrl_read("R7 lower lane only");
        check16("R7 route kept", {8'h00, reg_rdata[15:8]}, 16'h0000);
        check_pads("R7 pads after lane writes");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule